// File: doc/BRIEF.md
# Two-Level Priority Bus Arbiter

This block grants ownership of a shared multi-master message bus to one requester at a time. Up to `NUM_REQ` masters (port controllers and a switching engine) each pull their own active-low request line. Any master with frame data waiting also pulls a shared active-low high-priority line. While that line is low, only masters that flag pending data may win. Masters that only carry commands wait until no data request remains. Within a level, the winner is found by round robin, starting at the index after the last master granted.

A grant stays active while the winner runs its message. The message is framed by a shared active-low envelope. The grant drops on the clock edge that sees the envelope high again, and the bus then stays idle for one cycle before the next grant. A winner that never opens its envelope loses the grant after `TIMEOUT` cycles.

The arbiter also tracks how many data grants it has issued over the last `WINDOW` cycles. It pulls an active-low overload output whenever that count reaches a threshold supplied on an input.

Top module: `prio_bus_arbiter`

## Requirements
- R1: At most one bit of `gnt_n` is low at any time. During reset all grants are high.
- R2: A grant is issued only on a clock edge at which the arbiter is idle and at least one eligible request is low. It goes to a requester whose `req_n` bit was low at that edge.
- R3: When `hp_req_n` is low at the arbitration edge, only requesters with `req_n` low and `data_pend` high are eligible. If there is no such requester, no grant is issued.
- R4: When `hp_req_n` is high at the arbitration edge, every requester with `req_n` low is eligible, whatever its `data_pend` bit.
- R5: Among eligible requesters, the winner is the first one found searching upward from the index after the most recently granted requester, wrapping from `NUM_REQ-1` to 0. After reset the search starts at index 0.
- R6: Once `env_n` has been sampled low while a grant is active, the grant holds until an edge samples `env_n` high. That edge removes the grant.
- R7: Ownership never moves directly from one requester to another. After a grant is removed, at least one full cycle passes with every grant high.
- R8: If `env_n` is sampled high on each of the `TIMEOUT` edges that follow a grant, the grant is removed on the `TIMEOUT`-th of those edges.
- R9: `ovld_n` is low exactly when the number of data grants issued in the last `WINDOW` clock edges is at least `ovld_thresh`. A data grant is one issued while `hp_req_n` is low. A threshold of 0 keeps `ovld_n` low.
- R10: Grants issued while `hp_req_n` is high are command grants. They do not add to the overload count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_n | input | NUM_REQ | Per-requester bus request, active low |
| data_pend | input | NUM_REQ | High when the requester has frame data to send |
| hp_req_n | input | 1 | Shared high-priority request, active low |
| env_n | input | 1 | Shared message envelope, active low |
| ovld_thresh | input | $clog2(WINDOW+1) | Data grant count that signals overload |
| gnt_n | output | NUM_REQ | Per-requester bus grant, active low |
| ovld_n | output | 1 | Forwarding budget exhausted, active low |

## Verification
The bench builds the arbiter with `NUM_REQ=4`, `TIMEOUT=4` and `WINDOW=32`. With only four requesters, the round-robin pointer wraps within a handful of messages. The short window lets data grants age out of the overload count after a few dozen idle cycles, so the flag can be seen both rising and falling again. A timeout of four makes the abandoned-grant path and the immediate re-grant that follows it quick to reach.

// File: rtl/arb_pkg.sv
package arb_pkg;
   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_GRANTED = 2'd1,
      ST_BUSY    = 2'd2
   } arb_state_e;
endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
   parameter int N     = 9,
   parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     cand,
   input  logic [IDX_W-1:0] last,
   output logic             found,
   output logic [IDX_W-1:0] win_idx,
   output logic [N-1:0]     win_oh
);
   if (N < 2) begin : g_bad_n
      $error("arb_rr_pick: N must be at least 2");
   end

   // Search upward from the slot after the last winner, wrapping round.
   always_comb begin
      found   = 1'b0;
      win_idx = '0;
      for (int i = 1; i <= N; i++) begin
         int p;
         p = (int'(last) + i) % N;
         if (!found && cand[p[IDX_W-1:0]]) begin
            found   = 1'b1;
            win_idx = p[IDX_W-1:0];
         end
      end
   end

   for (genvar g = 0; g < N; g++) begin : g_oh
      assign win_oh[g] = found && (win_idx == IDX_W'(g));
   end
endmodule

// File: rtl/arb_ovld_window.sv
module arb_ovld_window #(
   parameter int WINDOW = 256,
   parameter int CNT_W  = $clog2(WINDOW + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             event_i,
   input  logic [CNT_W-1:0] thresh_i,
   output logic             ovld_o
);
   if (WINDOW < 2) begin : g_bad_win
      $error("arb_ovld_window: WINDOW must be at least 2");
   end

   logic [WINDOW-1:0] hist_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              expire;

   assign expire = hist_q[WINDOW-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
         cnt_q  <= '0;
      end else begin
         hist_q <= {hist_q[WINDOW-2:0], event_i};
         cnt_q  <= cnt_q + CNT_W'(event_i) - CNT_W'(expire);
      end
   end

   assign ovld_o = (cnt_q >= thresh_i);

   // The running count can never exceed the window length (R9).
   assert_cnt_bound_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt_q) <= WINDOW);
endmodule

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter #(
   parameter int NUM_REQ = 9,
   parameter int TIMEOUT = 4,
   parameter int WINDOW  = 256,
   localparam int IDX_W  = $clog2(NUM_REQ),
   localparam int TMR_W  = $clog2(TIMEOUT + 1),
   localparam int CNT_W  = $clog2(WINDOW + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_REQ-1:0] req_n,
   input  logic [NUM_REQ-1:0] data_pend,
   input  logic               hp_req_n,
   input  logic               env_n,
   input  logic [CNT_W-1:0]   ovld_thresh,
   output logic [NUM_REQ-1:0] gnt_n,
   output logic               ovld_n
);
   import arb_pkg::*;

   if (NUM_REQ < 2) begin : g_bad_req
      $error("prio_bus_arbiter: NUM_REQ must be at least 2");
   end
   if (TIMEOUT < 1) begin : g_bad_to
      $error("prio_bus_arbiter: TIMEOUT must be at least 1");
   end

   arb_state_e         state_q;
   logic [TMR_W-1:0]   timer_q;
   logic [IDX_W-1:0]   last_q;
   logic [NUM_REQ-1:0] gnt_q;

   logic [NUM_REQ-1:0] req, cand, win_oh;
   logic               hp, found, issue, data_ev, ovld;
   logic [IDX_W-1:0]   win_idx;

   assign req  = ~req_n;
   assign hp   = ~hp_req_n;
   assign cand = hp ? (req & data_pend) : req;

   arb_rr_pick #(.N(NUM_REQ), .IDX_W(IDX_W)) u_pick (
      .cand    (cand),
      .last    (last_q),
      .found   (found),
      .win_idx (win_idx),
      .win_oh  (win_oh)
   );

   assign issue   = (state_q == ST_IDLE) && found;
   assign data_ev = issue && hp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         timer_q <= '0;
         last_q  <= IDX_W'(NUM_REQ - 1);
         gnt_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (found) begin
                  gnt_q   <= win_oh;
                  last_q  <= win_idx;
                  timer_q <= '0;
                  state_q <= ST_GRANTED;
               end
            end
            ST_GRANTED: begin
               if (!env_n) begin
                  state_q <= ST_BUSY;
               end else if (timer_q == TMR_W'(TIMEOUT - 1)) begin
                  gnt_q   <= '0;
                  state_q <= ST_IDLE;
               end else begin
                  timer_q <= timer_q + 1'b1;
               end
            end
            ST_BUSY: begin
               if (env_n) begin
                  gnt_q   <= '0;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   arb_ovld_window #(.WINDOW(WINDOW), .CNT_W(CNT_W)) u_ovld (
      .clk      (clk),
      .rst_n    (rst_n),
      .event_i  (data_ev),
      .thresh_i (ovld_thresh),
      .ovld_o   (ovld)
   );

   assign gnt_n  = ~gnt_q;
   assign ovld_n = ~ovld;

   assert_one_grant_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~gnt_n));

   assert_grant_from_req_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|gnt_q) |-> (($past(req) & gnt_q) != '0));

   assert_data_first_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(|gnt_q) && $past(hp)) |-> (($past(data_pend) & gnt_q) != '0));

   assert_hold_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_BUSY && !env_n) |=> $stable(gnt_q));

   assert_no_handover_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      ((|$past(gnt_q)) && (|gnt_q)) |-> (gnt_q == $past(gnt_q)));

   assert_timer_range_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_GRANTED) |-> (int'(timer_q) < TIMEOUT));
endmodule

// File: tb/prio_bus_arbiter_tb_top.sv
module prio_bus_arbiter_tb_top;
   localparam int N   = 4;
   localparam int TO  = 4;
   localparam int WIN = 32;
   localparam int CW  = $clog2(WIN + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [N-1:0]  req_n, data_pend;
   logic          hp_req_n, env_n;
   logic [CW-1:0] thresh;
   logic [N-1:0]  gnt_n;
   logic          ovld_n;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   logic [N-1:0] exp_q[$];
   string        tag_q[$];

   prio_bus_arbiter #(.NUM_REQ(N), .TIMEOUT(TO), .WINDOW(WIN)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_n(req_n), .data_pend(data_pend),
      .hp_req_n(hp_req_n), .env_n(env_n), .ovld_thresh(thresh),
      .gnt_n(gnt_n), .ovld_n(ovld_n));

   task automatic chk(input bit ok, input string rq, input string what,
                      input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, expv);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic drive(input logic [N-1:0] rq, input logic [N-1:0] dp,
                        input bit hp, input logic [N-1:0] expv, input string tag);
      @(negedge clk);
      req_n     = ~rq;
      data_pend = dp;
      hp_req_n  = ~hp;
      if (expv != '0) begin
         exp_q.push_back(expv);
         tag_q.push_back(tag);
      end
   endtask

   task automatic finish_msg();
      @(negedge clk);
      req_n = '1; data_pend = '0; hp_req_n = 1'b1; env_n = 1'b0;
      tick();
      tick();
      @(negedge clk);
      chk(gnt_n != '1, "R6", "grant held in envelope", int'(gnt_n), 0);
      env_n = 1'b1;
      tick();
      chk(gnt_n == '1, "R6", "grant dropped on envelope rise", int'(gnt_n), int'({N{1'b1}}));
      tick();
   endtask

   // Monitor: compare each newly issued grant against the scoreboard.
   initial begin
      logic prev;
      prev = 1'b0;
      forever begin
         logic [N-1:0] e;
         string t;
         @(posedge clk);
         #2;
         if (rst_n) begin
            if (!prev && (gnt_n != '1)) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R2", "unexpected grant", int'(~gnt_n), 0);
               end else begin
                  e = exp_q.pop_front();
                  t = tag_q.pop_front();
                  chk(~gnt_n == e, t, "grant winner", int'(~gnt_n), int'(e));
               end
            end
            prev = (gnt_n != '1);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      req_n = '1; data_pend = '0; hp_req_n = 1'b1; env_n = 1'b1; thresh = CW'(31);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(gnt_n == '1, "R1", "grants high in reset", int'(gnt_n), int'({N{1'b1}}));
      chk(ovld_n == 1'b1, "R9", "no overload in reset", int'(ovld_n), 1);
      rst_n = 1'b1;
      tick();

      // Command level round robin (R4, R5)
      drive(4'b1111, 4'b0000, 1'b0, 4'b0001, "R4"); tick(); finish_msg();
      drive(4'b1111, 4'b0000, 1'b0, 4'b0010, "R5"); tick(); finish_msg();
      drive(4'b1001, 4'b0000, 1'b0, 4'b1000, "R5"); tick(); finish_msg();
      drive(4'b0011, 4'b0000, 1'b0, 4'b0001, "R5"); tick(); finish_msg();

      // Data level (R3)
      drive(4'b1111, 4'b0100, 1'b1, 4'b0100, "R3"); tick(); finish_msg();
      drive(4'b1010, 4'b0010, 1'b1, 4'b0010, "R3"); tick(); finish_msg();
      drive(4'b0001, 4'b0000, 1'b1, 4'b0000, "");
      repeat (3) tick();
      chk(gnt_n == '1, "R3", "no grant without data requester", int'(gnt_n), int'({N{1'b1}}));
      @(negedge clk); req_n = '1; hp_req_n = 1'b1;
      tick();
      drive(4'b1100, 4'b1000, 1'b0, 4'b0100, "R4"); tick(); finish_msg();

      // Timeout and re-grant (R8, R7)
      drive(4'b1000, 4'b0000, 1'b0, 4'b1000, "R8");
      tick();
      for (int k = 1; k < TO; k++) begin
         tick();
         chk(gnt_n[3] == 1'b0, "R8", "grant held before timeout", int'(gnt_n), int'(4'b0111));
      end
      exp_q.push_back(4'b1000); tag_q.push_back("R7");
      tick();
      chk(gnt_n == '1, "R8", "grant withdrawn at timeout", int'(gnt_n), int'({N{1'b1}}));
      tick();
      chk(gnt_n == 4'b0111, "R7", "re-grant after idle cycle", int'(gnt_n), int'(4'b0111));
      finish_msg();

      // Turnaround with a second requester waiting (R7)
      drive(4'b0011, 4'b0000, 1'b0, 4'b0001, "R5");
      tick();
      @(negedge clk); req_n = 4'b1101; env_n = 1'b0;
      tick();
      @(negedge clk); env_n = 1'b1;
      exp_q.push_back(4'b0010); tag_q.push_back("R7");
      tick();
      chk(gnt_n == '1, "R7", "idle cycle between owners", int'(gnt_n), int'({N{1'b1}}));
      tick();
      finish_msg();

      // Overload window (R9, R10)
      @(negedge clk); thresh = CW'(2);
      repeat (40) tick();
      chk(ovld_n == 1'b1, "R9", "idle window not overloaded", int'(ovld_n), 1);
      drive(4'b0001, 4'b0001, 1'b1, 4'b0001, "R3"); tick();
      chk(ovld_n == 1'b1, "R9", "one data grant below threshold", int'(ovld_n), 1);
      finish_msg();
      drive(4'b0100, 4'b0000, 1'b0, 4'b0100, "R5"); tick();
      chk(ovld_n == 1'b1, "R10", "command grant not counted", int'(ovld_n), 1);
      finish_msg();
      drive(4'b1000, 4'b1000, 1'b1, 4'b1000, "R3"); tick();
      chk(ovld_n == 1'b0, "R9", "threshold reached", int'(ovld_n), 0);
      finish_msg();
      repeat (40) tick();
      chk(ovld_n == 1'b1, "R9", "grants aged out of window", int'(ovld_n), 1);
      @(negedge clk); thresh = '0;
      #1;
      chk(ovld_n == 1'b0, "R9", "zero threshold overloads", int'(ovld_n), 0);

      tick();
      chk(exp_q.size() == 0, "R2", "all expected grants seen", exp_q.size(), 0);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule